// File: doc/BRIEF.md
# UART Modem Handshake Control and Status

This block holds the modem handshake side of a UART. A small control word sets two request outputs, data-terminal-ready and request-to-send, and a diagnostic loopback switch. A status byte reports the present level of the four handshake inputs (clear-to-send, data-set-ready, ring, carrier-detect) beside four sticky change flags. The block raises a modem status interrupt while any change flag is set and the interrupt enable is high.

All four inputs are asynchronous active-low pins. Each one passes through a synchroniser before any edge detection. The status levels are the complements of the pins. Clear-to-send, data-set-ready and carrier-detect flag any change. The ring flag catches only the end of a ring, which is the pin going from low to high. Reading the status byte clears the change flags, but a change that lands in the same cycle as the read is kept. In loopback the request outputs feed the status inputs internally, the ring and carrier levels read as inactive, and the external request pins are held inactive. The serial data path and the register bus are outside this block.

Top module: `uart_modem_ctl`

## Requirements
- R1: A write (`ctl_wr` high) loads `ctl_wdata`: bit 0 = DTR request, bit 1 = RTS request, bit 2 = loopback. Outside loopback, `dtr_n` is low exactly when the stored DTR bit is 1 and `rts_n` is low exactly when the stored RTS bit is 1, from the cycle after the write.
- R2: While the stored loopback bit is 1, `dtr_n` and `rts_n` are both held high (inactive).
- R3: Status byte layout: bit 4 CTS level, bit 5 DSR level, bit 6 RI level, bit 7 DCD level. Each level is the complement of its pin, and it shows a pin change after the third rising clock edge that follows it.
- R4: Bit 0 (delta CTS), bit 1 (delta DSR) and bit 3 (delta DCD) are set on any change of the matching level, in the cycle that level changes.
- R5: Bit 2 (trailing-edge RI) is set only when the RI level goes from 1 to 0, that is when `ri_n` goes from low to high. The opposite transition leaves it unchanged.
- R6: Change bits stay set until a read (`stat_rd` high for a cycle) clears them at the next edge. A change detected at that same edge leaves its bit set.
- R7: In loopback, the CTS level follows the stored RTS bit and the DSR level follows the stored DTR bit, one edge later. The RI and DCD levels read 0. The external input pins have no effect on the status.
- R8: `msi_irq` is high exactly when `ms_ien` is high and at least one change bit is set.
- R9: After reset the status byte is 0, `dtr_n` and `rts_n` are high and `msi_irq` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctl_wr | input | 1 | Control word write strobe |
| ctl_wdata | input | 3 | Control word: DTR, RTS, loopback |
| stat_rd | input | 1 | Status read strobe, clears change bits |
| ms_ien | input | 1 | Modem status interrupt enable |
| cts_n | input | 1 | Clear-to-send pin, active low, asynchronous |
| dsr_n | input | 1 | Data-set-ready pin, active low, asynchronous |
| ri_n | input | 1 | Ring pin, active low, asynchronous |
| dcd_n | input | 1 | Carrier-detect pin, active low, asynchronous |
| stat_q | output | 8 | Status byte: change bits [3:0], levels [7:4] |
| dtr_n | output | 1 | Data-terminal-ready pin, active low |
| rts_n | output | 1 | Request-to-send pin, active low |
| msi_irq | output | 1 | Modem status interrupt |

## Verification
A wrong level register shows up on the upper status nibble at the next clock. It also raises a false change bit at the edge where the register would have followed the pin, so the interrupt line shows the error too when it is enabled. A wrong change bit or a lost clear shows on the lower nibble and on `msi_irq` in the same cycle. A wrong synchroniser depth moves every level and change bit by whole cycles, and a comparison on every clock catches that after the first pin toggle. The control state is visible on the request pins one edge after a write, and in loopback it also shows on the CTS and DSR levels one edge after that.

// File: rtl/uart_modem_pkg.sv
// Shared constants and types for the modem handshake block.
// Assumes the line order CTS, DSR, RI, DCD in every line vector.
package uart_modem_pkg;
    localparam int LINES  = 4;
    localparam int CTS_I  = 0;
    localparam int DSR_I  = 1;
    localparam int RI_I   = 2;
    localparam int DCD_I  = 3;
    localparam int CTL_W  = 3;
    localparam int STAT_W = 2 * LINES;

    typedef logic [LINES-1:0] mdm_vec_t;

    typedef struct packed {
        logic loop;
        logic rts;
        logic dtr;
    } mdm_ctl_t;
endpackage

// File: rtl/mdm_sync.sv
// Multi-stage synchroniser for a vector of asynchronous inputs.
// Assumes STAGES >= 2. On reset every stage takes RST_VAL.
module mdm_sync #(
    parameter int          WIDTH   = 4,
    parameter int          STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    localparam int LAST = STAGES - 1;

    logic [STAGES-1:0][WIDTH-1:0] chain;

    // Shift the pin values one stage deeper every clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain <= {STAGES{RST_VAL}};
        end else begin
            chain <= {chain[LAST-1:0], async_i};
        end
    end

    assign sync_o = chain[LAST];
endmodule

// File: rtl/mdm_ctl_reg.sv
// Control word for the handshake outputs and the loopback switch.
// Drives the active-low request pins and holds them inactive in loopback.
module mdm_ctl_reg
    import uart_modem_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_i,
    input  logic [CTL_W-1:0] wdata_i,
    output mdm_ctl_t         ctl_o,
    output logic             dtr_n_o,
    output logic             rts_n_o
);
    mdm_ctl_t ctl_q;

    // Load the control word on a write strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else if (wr_i) begin
            ctl_q <= mdm_ctl_t'(wdata_i);
        end
    end

    assign ctl_o   = ctl_q;
    assign dtr_n_o = ~(ctl_q.dtr & ~ctl_q.loop);
    assign rts_n_o = ~(ctl_q.rts & ~ctl_q.loop);
endmodule

// File: rtl/mdm_status.sv
// Status levels and sticky change flags for the four handshake lines.
// Input lines are already synchronised and active low. Loopback
// replaces them with the request bits. RI flags its falling level only.
module mdm_status
    import uart_modem_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  mdm_vec_t          pins_n_i,
    input  mdm_ctl_t          ctl_i,
    input  logic              rd_i,
    output logic [STAT_W-1:0] stat_o,
    output logic              any_delta_o
);
    mdm_vec_t src;
    mdm_vec_t hit;
    mdm_vec_t lvl_q;
    mdm_vec_t dlt_q;

    // Select the level source: external pins or looped-back requests.
    always_comb begin
        if (ctl_i.loop) begin
            src        = '0;
            src[CTS_I] = ctl_i.rts;
            src[DSR_I] = ctl_i.dtr;
        end else begin
            src = ~pins_n_i;
        end
    end

    // Per-line change detection; the ring line takes only the trailing edge.
    for (genvar i = 0; i < LINES; i++) begin : g_edge
        if (i == RI_I) begin : g_trail
            assign hit[i] = lvl_q[i] & ~src[i];
        end else begin : g_any
            assign hit[i] = lvl_q[i] ^ src[i];
        end
    end

    // Track levels and keep change flags until a read clears them.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lvl_q <= '0;
            dlt_q <= '0;
        end else begin
            lvl_q <= src;
            dlt_q <= (rd_i ? '0 : dlt_q) | hit;
        end
    end

    assign stat_o      = {lvl_q, dlt_q};
    assign any_delta_o = |dlt_q;
endmodule

// File: rtl/uart_modem_ctl.sv
// Top of the UART modem handshake block: synchroniser, control word,
// status byte and interrupt gate. Pins are asynchronous and active low.
module uart_modem_ctl
    import uart_modem_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_wr,
    input  logic [CTL_W-1:0]  ctl_wdata,
    input  logic              stat_rd,
    input  logic              ms_ien,
    input  logic              cts_n,
    input  logic              dsr_n,
    input  logic              ri_n,
    input  logic              dcd_n,
    output logic [STAT_W-1:0] stat_q,
    output logic              dtr_n,
    output logic              rts_n,
    output logic              msi_irq
);
    mdm_vec_t pins_raw;
    mdm_vec_t pins_sync;
    mdm_ctl_t ctl;
    logic     any_delta;
    logic     loop_act;

    // Gather the pins in line order.
    always_comb begin
        pins_raw        = '1;
        pins_raw[CTS_I] = cts_n;
        pins_raw[DSR_I] = dsr_n;
        pins_raw[RI_I]  = ri_n;
        pins_raw[DCD_I] = dcd_n;
    end

    mdm_sync #(
        .WIDTH   (LINES),
        .STAGES  (SYNC_STAGES),
        .RST_VAL ({LINES{1'b1}})
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (pins_raw),
        .sync_o  (pins_sync)
    );

    mdm_ctl_reg u_ctl (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (ctl_wr),
        .wdata_i (ctl_wdata),
        .ctl_o   (ctl),
        .dtr_n_o (dtr_n),
        .rts_n_o (rts_n)
    );

    mdm_status u_stat (
        .clk         (clk),
        .rst_n       (rst_n),
        .pins_n_i    (pins_sync),
        .ctl_i       (ctl),
        .rd_i        (stat_rd),
        .stat_o      (stat_q),
        .any_delta_o (any_delta)
    );

    assign loop_act = ctl.loop;
    assign msi_irq  = ms_ien & any_delta;
endmodule

// File: rtl/uart_modem_ctl_chk.sv
// Property checker for uart_modem_ctl, attached by bind below.
// Relates control writes, request pins, status byte and interrupt.
module uart_modem_ctl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       ctl_wr,
    input logic [2:0] ctl_wdata,
    input logic       stat_rd,
    input logic       ms_ien,
    input logic [7:0] stat_q,
    input logic       dtr_n,
    input logic       rts_n,
    input logic       msi_irq,
    input logic       loop_act
);
    // R1
    ctl_pins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(ctl_wr) && !$past(ctl_wdata[2]) |->
            (dtr_n == !$past(ctl_wdata[0])) && (rts_n == !$past(ctl_wdata[1])));

    // R2
    loop_pins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        loop_act |-> dtr_n && rts_n);

    // R4
    dcts_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stat_q[0]) |-> stat_q[4] != $past(stat_q[4]));

    // R5
    teri_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stat_q[2]) |-> $past(stat_q[6]) && !stat_q[6]);

    // R6
    delta_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(stat_rd) |-> ((stat_q[3:0] & $past(stat_q[3:0])) == $past(stat_q[3:0])));

    // R7
    loop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(loop_act) |-> !stat_q[6] && !stat_q[7]);

    // R8
    irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ms_ien |-> !msi_irq);

    // R8
    irq_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(msi_irq) && $stable(ms_ien) |-> $past(stat_rd));
endmodule

bind uart_modem_ctl uart_modem_ctl_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctl_wr    (ctl_wr),
    .ctl_wdata (ctl_wdata),
    .stat_rd   (stat_rd),
    .ms_ien    (ms_ien),
    .stat_q    (stat_q),
    .dtr_n     (dtr_n),
    .rts_n     (rts_n),
    .msi_irq   (msi_irq),
    .loop_act  (loop_act)
);

// File: tb/uart_modem_ctl_bench.sv
`timescale 1ns/1ps
// Bench: behavioural per-cycle reference model compared on every clock,
// plus directed checks with hand-computed values.
module uart_modem_ctl_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ctl_wr = 1'b0;
    logic [2:0] ctl_wdata = '0;
    logic       stat_rd = 1'b0;
    logic       ms_ien = 1'b0;
    logic       cts_n = 1'b1;
    logic       dsr_n = 1'b1;
    logic       ri_n = 1'b1;
    logic       dcd_n = 1'b1;
    logic [7:0] stat_q;
    logic       dtr_n;
    logic       rts_n;
    logic       msi_irq;

    int total = 0;
    int bad = 0;
    bit cmp_on = 1'b0;

    always #4 clk = ~clk;

    uart_modem_ctl u_uart_modem_ctl (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctl_wr    (ctl_wr),
        .ctl_wdata (ctl_wdata),
        .stat_rd   (stat_rd),
        .ms_ien    (ms_ien),
        .cts_n     (cts_n),
        .dsr_n     (dsr_n),
        .ri_n      (ri_n),
        .dcd_n     (dcd_n),
        .stat_q    (stat_q),
        .dtr_n     (dtr_n),
        .rts_n     (rts_n),
        .msi_irq   (msi_irq)
    );

    // Reference model state: pin history queue, request bits, levels, flags.
    logic [3:0] pin_hist[$];
    bit m_dtr, m_rts, m_loop;
    bit [3:0] m_lvl, m_dlt;

    always @(posedge clk) begin
        bit [3:0] pin_old;
        bit [3:0] want;
        bit [3:0] chg;
        if (!rst_n) begin
            pin_hist = '{4'hF, 4'hF};
            m_dtr = 0; m_rts = 0; m_loop = 0;
            m_lvl = 0; m_dlt = 0;
        end else begin
            pin_old = pin_hist[0];
            if (m_loop) want = {1'b0, 1'b0, m_dtr, m_rts};
            else        want = ~pin_old;
            for (int i = 0; i < 4; i++) begin
                if (i == 2) chg[i] = m_lvl[i] && !want[i];
                else        chg[i] = m_lvl[i] != want[i];
            end
            m_dlt = (stat_rd ? 4'h0 : m_dlt) | chg;
            m_lvl = want;
            if (ctl_wr) begin
                m_dtr = ctl_wdata[0]; m_rts = ctl_wdata[1]; m_loop = ctl_wdata[2];
            end
            void'(pin_hist.pop_front());
            pin_hist.push_back({dcd_n, ri_n, dsr_n, cts_n});
        end
    end

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // Compare outputs with the model away from the active edge.
    always @(negedge clk) begin
        if (cmp_on && rst_n) begin
            check("R3 R7 levels", {4'h0, stat_q[7:4]}, {4'h0, m_lvl});
            check("R4 R5 R6 deltas", {4'h0, stat_q[3:0]}, {4'h0, m_dlt});
            check("R1 R2 pins", {6'h0, dtr_n, rts_n},
                  {6'h0, !(m_dtr && !m_loop), !(m_rts && !m_loop)});
            check("R8 irq", {7'h0, msi_irq}, {7'h0, ms_ien && (m_dlt != 0)});
        end
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic write_ctl(input logic [2:0] v);
        ctl_wr = 1'b1; ctl_wdata = v;
        step(1);
        ctl_wr = 1'b0;
    endtask

    task automatic read_stat();
        stat_rd = 1'b1;
        step(1);
        stat_rd = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        step(5);
        rst_n = 1'b1;
        step(1);
        // R9 reset state
        check("R9 reset status", stat_q, 8'h00);
        check("R9 reset pins", {6'h0, dtr_n, rts_n}, 8'h03);
        check("R9 reset irq", {7'h0, msi_irq}, 8'h00);
        cmp_on = 1'b1;

        // R1 request pins follow the control word
        write_ctl(3'b001);
        check("R1 dtr asserted", {6'h0, dtr_n, rts_n}, 8'h01);
        write_ctl(3'b010);
        check("R1 rts asserted", {6'h0, dtr_n, rts_n}, 8'h02);

        // R3 R4 CTS change, three edges of latency
        ms_ien = 1'b1;
        cts_n = 1'b0;
        step(2);
        check("R3 level not yet visible", stat_q, 8'h00);
        step(1);
        check("R3 R4 cts level and delta", stat_q, 8'h11);
        check("R8 irq on delta", {7'h0, msi_irq}, 8'h01);
        read_stat();
        check("R6 read clears", stat_q, 8'h10);

        // R5 ring: falling pin does not flag, rising pin does
        ri_n = 1'b0;
        step(4);
        check("R5 ring start no flag", stat_q, 8'h50);
        ri_n = 1'b1;
        step(4);
        check("R5 ring end flags", stat_q, 8'h14);
        read_stat();

        // R6 coincident change and read: DSR flag set first, then CTS change with read
        dsr_n = 1'b0;
        step(4);
        check("R6 dsr flag set", stat_q, 8'h32);
        cts_n = 1'b1;
        step(2);
        stat_rd = 1'b1;
        step(1);
        stat_rd = 1'b0;
        check("R6 coincident change kept", stat_q, 8'h21);
        read_stat();
        dsr_n = 1'b1;
        step(4);
        read_stat();

        // R2 R7 loopback: RTS drives CTS, DTR drives DSR, pins ignored
        write_ctl(3'b110);
        check("R2 pins inactive in loop", {6'h0, dtr_n, rts_n}, 8'h03);
        step(1);
        check("R7 loop levels", {4'h0, stat_q[7:4]}, 8'h01);
        read_stat();
        dcd_n = 1'b0; ri_n = 1'b0; dsr_n = 1'b0;
        step(5);
        check("R7 pins ignored", stat_q, 8'h10);
        write_ctl(3'b101);
        step(1);
        check("R7 loop swap", {4'h0, stat_q[7:4]}, 8'h02);
        write_ctl(3'b000);
        step(4);
        read_stat();
        ms_ien = 1'b0;
        step(1);
        check("R8 irq masked", {7'h0, msi_irq}, 8'h00);

        // Mixed stimulus against the model
        for (int k = 0; k < 600; k++) begin
            logic [31:0] r;
            r = $urandom;
            if (r[2:0] == 0) begin
                cts_n = r[4]; dsr_n = r[5]; ri_n = r[6]; dcd_n = r[7];
            end
            stat_rd = (r[10:8] == 0);
            ctl_wr = (r[14:11] == 0);
            ctl_wdata = r[17:15];
            if (r[21:18] == 0) ms_ien = r[22];
            step(1);
        end
        stat_rd = 1'b0; ctl_wr = 1'b0;
        step(2);
        cmp_on = 1'b0;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule